// File: doc/BRIEF.md
# Tagged Integer Add/Subtract Unit with Trap

This unit adds or subtracts two 32-bit tagged integers. In a tagged integer the two least significant bits are a type tag, and that tag must be zero for the value to count as a plain integer. One input selects the operation. A valid strobe qualifies each request, and the outcome appears on registered outputs one clock later.

A request fails when either operand carries a nonzero tag, or when the signed result does not fit in 32 bits. A failed request raises a one-cycle trap pulse. In that case the result register and the condition flags keep their old contents, so the surrounding pipeline can hand the fault to its trap logic with no architectural state disturbed. A request that passes writes the result and the four flags N, Z, V and C together.

Top module: `tagged_alu`

## Requirements
- R1: If bit 0 or bit 1 of `a_i` or of `b_i` is set on a valid request, `trap_o` is 1 in the following cycle, for either operation.
- R2: With `op_i`=0 (add), a valid request whose operands share bit 31 while the sum's bit 31 differs from it gives `trap_o`=1 in the next cycle.
- R3: With `op_i`=1 (subtract, a_i minus b_i), a valid request whose operands differ in bit 31 while the difference's bit 31 differs from that of `a_i` gives `trap_o`=1 in the next cycle.
- R4: A valid request that raises no trap loads `result_o` with a_i+b_i (op 0) or a_i-b_i (op 1), modulo 2^32, one cycle later, and `trap_o` stays 0.
- R5: On a request that raises no trap, the flags become N = result bit 31, Z = (result == 0), V = 0, and C = carry out of bit 31 for add or borrow (a_i < b_i unsigned) for subtract.
- R6: On a trapping request, `result_o` and all four flags keep their previous values, and `trap_o` is high for that single cycle only. It returns to 0 unless the next request also traps.
- R7: While `valid_i` is 0, `trap_o` is 0 in the next cycle and `result_o` and the flags do not change, whatever the operands.
- R8: Asserting `rst_ni` low clears `result_o`, all flags and `trap_o` at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Qualifies a request in this cycle |
| op_i | input | 1 | 0 = add, 1 = subtract |
| a_i | input | 32 | First operand (tagged) |
| b_i | input | 32 | Second operand (tagged) |
| result_o | output | 32 | Last successfully written result |
| trap_o | output | 1 | One-cycle tag-overflow trap pulse |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_v_o | output | 1 | Overflow flag (0 after any write) |
| flag_c_o | output | 1 | Carry (add) or borrow (subtract) |

## Verification
On every cycle the assertions check four things. A bad tag or a signed overflow always leads to a trap. A trap leaves the result and flags frozen. An idle cycle neither traps nor writes. A clean request writes the arithmetically expected result and flag values. The bench scenarios cover what a single cycle cannot show: operation sequences in which a run of traps must keep a result written several requests earlier, overflow at both ends of the signed range for both operations, and an asynchronous reset in the middle of a run that clears state already loaded.

// File: rtl/tagalu_pkg.sv
package tagalu_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } alu_flags_t;
endpackage

// File: rtl/tagalu_tag_check.sv
module tagalu_tag_check #(
  parameter int WIDTH    = 32,
  parameter int TAG_BITS = 2
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             tag_bad_o
);
  logic [TAG_BITS-1:0] tag_or;

  for (genvar i = 0; i < TAG_BITS; i++) begin : g_tag
    assign tag_or[i] = a_i[i] | b_i[i];
  end

  assign tag_bad_o = |tag_or;
endmodule

// File: rtl/tagalu_addsub.sv
module tagalu_addsub #(
  parameter int WIDTH = 32
) (
  input  tagalu_pkg::alu_op_e op_i,
  input  logic [WIDTH-1:0]    a_i,
  input  logic [WIDTH-1:0]    b_i,
  output logic [WIDTH-1:0]    res_o,
  output logic                carry_o,
  output logic                ovf_o
);
  import tagalu_pkg::*;

  localparam int MSB = WIDTH - 1;

  logic            is_sub;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   ext;

  assign is_sub = (op_i == OP_SUB);
  assign b_eff  = b_i ^ {WIDTH{is_sub}};
  assign ext    = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, is_sub};
  assign res_o  = ext[WIDTH-1:0];
  // subtract: carry-out of a + ~b + 1 is the inverse of borrow
  assign carry_o = is_sub ? ~ext[WIDTH] : ext[WIDTH];

  always_comb begin
    if (is_sub) ovf_o = (a_i[MSB] != b_i[MSB]) && (res_o[MSB] != a_i[MSB]);
    else        ovf_o = (a_i[MSB] == b_i[MSB]) && (res_o[MSB] != a_i[MSB]);
  end
endmodule

// File: rtl/tagalu_flags.sv
module tagalu_flags #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0]       res_i,
  input  logic                   carry_i,
  output tagalu_pkg::alu_flags_t flags_o
);
  always_comb begin
    flags_o.n = res_i[WIDTH-1];
    flags_o.z = (res_i == '0);
    flags_o.v = 1'b0;
    flags_o.c = carry_i;
  end
endmodule

// File: rtl/tagged_alu.sv
module tagged_alu #(
  parameter int WIDTH    = 32,
  parameter int TAG_BITS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] result_o,
  output logic             trap_o,
  output logic             flag_n_o,
  output logic             flag_z_o,
  output logic             flag_v_o,
  output logic             flag_c_o
);
  import tagalu_pkg::*;

  logic             tag_bad;
  logic             ovf;
  logic             carry;
  logic [WIDTH-1:0] sum;
  alu_flags_t       flags_d, flags_q;
  logic [WIDTH-1:0] result_q;
  logic             trap_q;
  logic             trap_cond;
  alu_op_e          op;

  assign op = alu_op_e'(op_i);

  tagalu_tag_check #(.WIDTH(WIDTH), .TAG_BITS(TAG_BITS)) u_tag (
    .a_i      (a_i),
    .b_i      (b_i),
    .tag_bad_o(tag_bad)
  );

  tagalu_addsub #(.WIDTH(WIDTH)) u_arith (
    .op_i   (op),
    .a_i    (a_i),
    .b_i    (b_i),
    .res_o  (sum),
    .carry_o(carry),
    .ovf_o  (ovf)
  );

  tagalu_flags #(.WIDTH(WIDTH)) u_flags (
    .res_i  (sum),
    .carry_i(carry),
    .flags_o(flags_d)
  );

  assign trap_cond = tag_bad | ovf;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
      flags_q  <= '0;
      trap_q   <= 1'b0;
    end else begin
      trap_q <= valid_i & trap_cond;
      // state commits only once the trap check has passed
      if (valid_i && !trap_cond) begin
        result_q <= sum;
        flags_q  <= flags_d;
      end
    end
  end

  assign result_o = result_q;
  assign trap_o   = trap_q;
  assign flag_n_o = flags_q.n;
  assign flag_z_o = flags_q.z;
  assign flag_v_o = flags_q.v;
  assign flag_c_o = flags_q.c;
endmodule

// File: rtl/tagged_alu_chk.sv
module tagged_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             op_i,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [WIDTH-1:0] result_o,
  input logic             trap_o,
  input logic             flag_n_o,
  input logic             flag_z_o,
  input logic             flag_v_o,
  input logic             flag_c_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0]   add_x, sub_x;
  logic [WIDTH-1:0] exp_res;
  logic             exp_c, tag_nz, add_ov, sub_ov, clean;
  logic [3:0]       flags_now;

  assign add_x     = {1'b0, a_i} + {1'b0, b_i};
  assign sub_x     = {1'b0, a_i} - {1'b0, b_i};
  assign exp_res   = op_i ? sub_x[WIDTH-1:0] : add_x[WIDTH-1:0];
  assign exp_c     = op_i ? sub_x[WIDTH] : add_x[WIDTH];
  assign tag_nz    = (a_i[1:0] != 2'b00) || (b_i[1:0] != 2'b00);
  assign add_ov    = !op_i && (a_i[MSB] == b_i[MSB]) && (add_x[MSB] != a_i[MSB]);
  assign sub_ov    = op_i && (a_i[MSB] != b_i[MSB]) && (sub_x[MSB] != a_i[MSB]);
  assign clean     = !tag_nz && !add_ov && !sub_ov;
  assign flags_now = {flag_n_o, flag_z_o, flag_v_o, flag_c_o};

  AST_TAG_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && tag_nz |=> trap_o); // R1
  AST_ADD_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && add_ov |=> trap_o); // R2
  AST_SUB_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && sub_ov |=> trap_o); // R3
  AST_CLEAN_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && clean |=> !trap_o && result_o == $past(exp_res)); // R4
  AST_CLEAN_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && clean |=> flag_n_o == result_o[MSB] && flag_z_o == (result_o == '0)
                         && !flag_v_o && flag_c_o == $past(exp_c)); // R5
  AST_TRAP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> $stable(result_o) && $stable(flags_now)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !trap_o && $stable(result_o) && $stable(flags_now)); // R7
endmodule

bind tagged_alu tagged_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .op_i    (op_i),
  .a_i     (a_i),
  .b_i     (b_i),
  .result_o(result_o),
  .trap_o  (trap_o),
  .flag_n_o(flag_n_o),
  .flag_z_o(flag_z_o),
  .flag_v_o(flag_v_o),
  .flag_c_o(flag_c_o)
);

// File: tb/tagged_alu_tb_top.sv
module tagged_alu_tb_top;
  typedef struct packed {
    logic        op;
    logic [31:0] a;
    logic [31:0] b;
    logic        trap;
    logic [31:0] res;
    logic [3:0]  nzvc;
  } vec_t;

  localparam int NVEC = 15;
  // expected res/nzvc are the register contents after the row (held on trap)
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 32'h00000004, 32'h00000008, 1'b0, 32'h0000000C, 4'b0000},
    '{1'b1, 32'h00000008, 32'h00000004, 1'b0, 32'h00000004, 4'b0000},
    '{1'b1, 32'h00000004, 32'h00000008, 1'b0, 32'hFFFFFFFC, 4'b1001},
    '{1'b0, 32'hFFFFFFFC, 32'h00000004, 1'b0, 32'h00000000, 4'b0101},
    '{1'b0, 32'h7FFFFFFC, 32'h00000004, 1'b1, 32'h00000000, 4'b0101},
    '{1'b0, 32'h00000001, 32'h00000000, 1'b1, 32'h00000000, 4'b0101},
    '{1'b0, 32'h80000000, 32'h80000000, 1'b1, 32'h00000000, 4'b0101},
    '{1'b1, 32'h80000000, 32'h00000004, 1'b1, 32'h00000000, 4'b0101},
    '{1'b1, 32'h7FFFFFFC, 32'hFFFFFFFC, 1'b1, 32'h00000000, 4'b0101},
    '{1'b1, 32'h00000000, 32'h80000000, 1'b1, 32'h00000000, 4'b0101},
    '{1'b1, 32'h80000000, 32'h80000000, 1'b0, 32'h00000000, 4'b0100},
    '{1'b0, 32'h40000000, 32'h3FFFFFFC, 1'b0, 32'h7FFFFFFC, 4'b0000},
    '{1'b1, 32'h00000000, 32'h00000002, 1'b1, 32'h7FFFFFFC, 4'b0000},
    '{1'b0, 32'hFFFFFFF0, 32'hFFFFFFF0, 1'b0, 32'hFFFFFFE0, 4'b1001},
    '{1'b1, 32'h00000010, 32'h00000010, 1'b0, 32'h00000000, 4'b0100}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        op_i = 1'b0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic [31:0] result_o;
  logic        trap_o, flag_n_o, flag_z_o, flag_v_o, flag_c_o;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2 clk_i = ~clk_i;

  tagged_alu dut_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .op_i    (op_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .result_o(result_o),
    .trap_o  (trap_o),
    .flag_n_o(flag_n_o),
    .flag_z_o(flag_z_o),
    .flag_v_o(flag_v_o),
    .flag_c_o(flag_c_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] nzvc();
    return {flag_n_o, flag_z_o, flag_v_o, flag_c_o};
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // drive at negedge, sample at the negedge after the capturing posedge
  task automatic issue(input logic v, input logic op, input logic [31:0] a, input logic [31:0] b);
    valid_i = v; op_i = op; a_i = a; b_i = b;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R8: outputs cleared under reset
    chk("R8 reset result", result_o, 32'h0);
    chk("R8 reset flags", {28'h0, nzvc()}, 32'h0);
    chk("R8 reset trap", {31'h0, trap_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NVEC; i++) begin
      issue(1'b1, VECS[i].op, VECS[i].a, VECS[i].b);
      chk(VECS[i].trap ? "R1/R2/R3 trap" : "R4 no trap", {31'h0, trap_o}, {31'h0, VECS[i].trap});
      chk(VECS[i].trap ? "R6 result held" : "R4 result", result_o, VECS[i].res);
      chk(VECS[i].trap ? "R6 flags held" : "R5 flags", {28'h0, nzvc()}, {28'h0, VECS[i].nzvc});
      if (VECS[i].trap) begin
        issue(1'b0, 1'b0, 32'h0, 32'h0);
        chk("R6 trap one cycle", {31'h0, trap_o}, 32'h0);
      end
    end

    // R7: idle cycles with operands that would trap or write
    issue(1'b0, 1'b0, 32'h00000001, 32'h00000004);
    chk("R7 idle trap", {31'h0, trap_o}, 32'h0);
    issue(1'b0, 1'b1, 32'h00000100, 32'h00000004);
    chk("R7 idle result", result_o, 32'h0);
    chk("R7 idle flags", {28'h0, nzvc()}, 32'h4);

    // R6: back-to-back traps keep trap high, then it drops
    issue(1'b1, 1'b0, 32'h00000002, 32'h0);
    chk("R6 b2b trap 1", {31'h0, trap_o}, 32'h1);
    issue(1'b1, 1'b1, 32'h0, 32'h00000003);
    chk("R6 b2b trap 2", {31'h0, trap_o}, 32'h1);
    issue(1'b1, 1'b0, 32'h00000020, 32'h00000040);
    chk("R6 trap drops", {31'h0, trap_o}, 32'h0);
    chk("R4 after traps", result_o, 32'h00000060);

    // R8: asynchronous reset mid-run
    issue(1'b0, 1'b0, 32'h0, 32'h0);
    #1 rst_ni = 1'b0;
    #0.5;
    chk("R8 async result", result_o, 32'h0);
    chk("R8 async flags", {28'h0, nzvc()}, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule